// File: doc/BRIEF.md
# System Coprocessor Status and Cause Unit

This block keeps the system-control register set of a simple 32-bit RISC core. It holds thirty-two 32-bit control words. Three of them have fixed roles: the processor status word at index 12, the exception cause word at index 13, and the exception return address at index 14. The core's execute stage uses it in five ways. It writes a control word from a general register. It reads a control word back combinationally. It issues a return-from-exception that pops the status mode/enable stack. It raises a system-call request. It supplies the address of the current instruction and a flag that says whether that instruction sits in a branch delay slot.

Two kinds of event take an exception. One is a system call. The other is a software interrupt, found the cycle after any write to status or cause, when an enabled pending bit meets the global interrupt enable. On entry the unit pushes the status stack, records the cause code and the delay-slot flag, and loads the return address. It reports the event on `exc_taken` with the code on `exc_code`. Fetch redirection belongs to the surrounding pipeline.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After reset every control word reads as zero and `exc_taken` is low.
- R2: `rd_data` shows the word at `rd_addr` in the same cycle, with no clock edge in between.
- R3: A write to any index other than 12 and 13 stores all 32 bits unchanged, readable after the capturing edge.
- R4: A write to index 12 (status) stores all 32 bits unchanged.
- R5: A write to index 13 (cause) stores the value with bits 15:10 cleared; those bits read zero at all times.
- R6: A return-from-exception keeps status bits 31:4 and loads status bits 3:0 from the old status bits 5:2.
- R7: A system call raises `exc_taken` in the same cycle with `exc_code` = 8. At the next edge the cause bits 6:2 become 8, cause bit 31 takes `in_delay`, the other cause bits are kept, and index 14 takes `exc_pc`.
- R8: On any exception entry, status bits 5:0 become the old bits 3:0 followed by two zero bits, and bits 31:6 are kept.
- R9: In the cycle after the edge that stores a write to status or cause, an exception with `exc_code` = 0 is raised if bits 9:8 of (status AND cause) are nonzero and status bit 0 is set. At the next edge it enters exactly as in R7 (code 0 in cause bits 6:2, `in_delay` into bit 31, `exc_pc` into index 14) and R8. No such exception is raised in any other cycle.
- R10: Within one cycle the order of precedence is system call, then software interrupt, then return-from-exception, then write. A lower-ranked operation in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write a control word this cycle |
| wr_addr | input | 5 | Index of the word to write |
| wr_data | input | 32 | Value to write |
| rd_addr | input | 5 | Index of the word to read |
| rd_data | output | 32 | Word at `rd_addr` |
| rfe_en | input | 1 | Return-from-exception stack pop |
| sys_req | input | 1 | System-call exception request |
| exc_pc | input | 32 | Address saved into index 14 on exception entry |
| in_delay | input | 1 | Current instruction sits in a branch delay slot |
| exc_taken | output | 1 | An exception is entered at the coming edge |
| exc_code | output | 5 | Code of the exception being entered |

## Verification
The read port is combinational. Each read check therefore sets `rd_addr` and samples `rd_data` one nanosecond later, well clear of any edge. Writes, stack pops and exception entries show up in the registers one edge after the cycle that presents them. A system call shows on `exc_taken` in its own cycle. A software interrupt appears only in the cycle after the write edge, and its register effects land at the edge after that. Every scenario drives its stimulus on the falling edge, samples `exc_taken` within the same low phase, and reads results only after the following falling edge. It also confirms that `exc_taken` is low again one cycle later.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  localparam int XLEN       = 32;
  localparam int CODE_W     = 5;
  localparam int IDX_STATUS = 12;
  localparam int IDX_CAUSE  = 13;
  localparam int IDX_EPC    = 14;
  localparam int SWI_LO     = 8;
  localparam int SWI_HI     = 9;
  localparam logic [XLEN-1:0]   CAUSE_RO_MASK = 32'h0000_FC00;
  localparam logic [CODE_W-1:0] CODE_INT      = 5'd0;
  localparam logic [CODE_W-1:0] CODE_SYS      = 5'd8;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_WRITE,
    OP_POP,
    OP_ENTER
  } ctrl_op_e;
endpackage

// File: rtl/sys_ctrl_swi.sv
module sys_ctrl_swi
  import sys_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [XLEN-1:0] status_q,
  input  logic [XLEN-1:0] cause_q,
  output logic            fire
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign fire = pend_q & status_q[0] &
                (|(status_q[SWI_HI:SWI_LO] & cause_q[SWI_HI:SWI_LO]));

  // R9: a check is only armed by a write, so a fire never runs two cycles back to back
  assert_swi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/sys_ctrl_update.sv
module sys_ctrl_update
  import sys_ctrl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              rfe_en,
  input  logic              sys_req,
  input  logic              swi_fire,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              in_delay,
  input  logic [XLEN-1:0]   status_q,
  input  logic [XLEN-1:0]   cause_q,
  output logic              gen_we,
  output logic              st_we,
  output logic [XLEN-1:0]   st_d,
  output logic              ca_we,
  output logic [XLEN-1:0]   ca_d,
  output logic              epc_we,
  output logic [XLEN-1:0]   epc_d,
  output logic              arm,
  output logic              exc_taken,
  output logic [CODE_W-1:0] exc_code
);
  ctrl_op_e          op;
  logic [XLEN-1:0]   status_enter;
  logic [XLEN-1:0]   status_pop;
  logic [XLEN-1:0]   cause_enter;
  logic              hit_status;
  logic              hit_cause;

  // R10: fixed precedence among the four operations
  always_comb begin
    if (sys_req || swi_fire) op = OP_ENTER;
    else if (rfe_en)         op = OP_POP;
    else if (wr_en)          op = OP_WRITE;
    else                     op = OP_IDLE;
  end

  assign exc_taken    = (op == OP_ENTER);
  assign exc_code     = sys_req ? CODE_SYS : CODE_INT;
  assign hit_status   = (wr_addr == ADDR_W'(IDX_STATUS));
  assign hit_cause    = (wr_addr == ADDR_W'(IDX_CAUSE));
  assign status_enter = {status_q[XLEN-1:6], status_q[3:0], 2'b00};
  assign status_pop   = {status_q[XLEN-1:4], status_q[5:2]};
  assign cause_enter  = {in_delay, cause_q[XLEN-2:7], exc_code, cause_q[1:0]};

  always_comb begin
    gen_we = 1'b0;
    st_we  = 1'b0;
    st_d   = status_q;
    ca_we  = 1'b0;
    ca_d   = cause_q;
    epc_we = 1'b0;
    epc_d  = exc_pc;
    arm    = 1'b0;
    case (op)
      OP_ENTER: begin
        st_we  = 1'b1;
        st_d   = status_enter;
        ca_we  = 1'b1;
        ca_d   = cause_enter;
        epc_we = 1'b1;
      end
      OP_POP: begin
        st_we = 1'b1;
        st_d  = status_pop;
      end
      OP_WRITE: begin
        if (hit_status) begin
          st_we = 1'b1;
          st_d  = wr_data;
          arm   = 1'b1;
        end else if (hit_cause) begin
          ca_we = 1'b1;
          ca_d  = wr_data & ~CAUSE_RO_MASK;
          arm   = 1'b1;
        end else begin
          gen_we = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sys_ctrl_regfile.sv
module sys_ctrl_regfile
  import sys_ctrl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_we,
  input  logic [ADDR_W-1:0] gen_addr,
  input  logic [XLEN-1:0]   gen_data,
  input  logic              st_we,
  input  logic [XLEN-1:0]   st_d,
  input  logic              ca_we,
  input  logic [XLEN-1:0]   ca_d,
  input  logic              epc_we,
  input  logic [XLEN-1:0]   epc_d,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [XLEN-1:0]   rd_data,
  output logic [XLEN-1:0]   status_q,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   epc_q
);
  localparam int NREGS = 1 << ADDR_W;

  logic [XLEN-1:0] words [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_word
    logic            en;
    logic [XLEN-1:0] d;
    logic [XLEN-1:0] q;
    logic            gen_hit;

    assign gen_hit = gen_we && (gen_addr == ADDR_W'(g));

    if (g == IDX_STATUS) begin : g_status
      assign en = st_we;
      assign d  = st_d;
    end else if (g == IDX_CAUSE) begin : g_cause
      assign en = ca_we;
      assign d  = ca_d;
    end else if (g == IDX_EPC) begin : g_epc
      assign en = epc_we | gen_hit;
      assign d  = epc_we ? epc_d : gen_data;
    end else begin : g_plain
      assign en = gen_hit;
      assign d  = gen_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign words[g] = q;
  end

  assign rd_data  = words[rd_addr];
  assign status_q = words[IDX_STATUS];
  assign cause_q  = words[IDX_CAUSE];
  assign epc_q    = words[IDX_EPC];

  assert_gen_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gen_we && !epc_we |=> words[$past(gen_addr)] == $past(gen_data));

  assert_cause_hole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[15:10] == 6'd0);
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sys_ctrl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [XLEN-1:0]   rd_data,
  input  logic              rfe_en,
  input  logic              sys_req,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              in_delay,
  output logic              exc_taken,
  output logic [CODE_W-1:0] exc_code
);
  logic            gen_we, st_we, ca_we, epc_we, arm, swi_fire;
  logic [XLEN-1:0] st_d, ca_d, epc_d;
  logic [XLEN-1:0] status_q, cause_q, epc_q;

  sys_ctrl_swi u_swi (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .status_q (status_q),
    .cause_q  (cause_q),
    .fire     (swi_fire)
  );

  sys_ctrl_update #(.ADDR_W(ADDR_W)) u_update (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rfe_en    (rfe_en),
    .sys_req   (sys_req),
    .swi_fire  (swi_fire),
    .exc_pc    (exc_pc),
    .in_delay  (in_delay),
    .status_q  (status_q),
    .cause_q   (cause_q),
    .gen_we    (gen_we),
    .st_we     (st_we),
    .st_d      (st_d),
    .ca_we     (ca_we),
    .ca_d      (ca_d),
    .epc_we    (epc_we),
    .epc_d     (epc_d),
    .arm       (arm),
    .exc_taken (exc_taken),
    .exc_code  (exc_code)
  );

  sys_ctrl_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_we   (gen_we),
    .gen_addr (wr_addr),
    .gen_data (wr_data),
    .st_we    (st_we),
    .st_d     (st_d),
    .ca_we    (ca_we),
    .ca_d     (ca_d),
    .epc_we   (epc_we),
    .epc_d    (epc_d),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .status_q (status_q),
    .cause_q  (cause_q),
    .epc_q    (epc_q)
  );

  assert_pop_stack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_en && !exc_taken |=>
      status_q[XLEN-1:4] == $past(status_q[XLEN-1:4]) &&
      status_q[3:0] == $past(status_q[5:2]));

  assert_sys_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req |-> exc_taken && exc_code == CODE_SYS);

  assert_sys_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req |=> cause_q[6:2] == CODE_SYS && epc_q == $past(exc_pc) &&
                cause_q[XLEN-1] == $past(in_delay));

  assert_enter_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> status_q[5:0] == {$past(status_q[3:0]), 2'b00});

  assert_swi_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken && !sys_req |->
      status_q[0] && (|(status_q[SWI_HI:SWI_LO] & cause_q[SWI_HI:SWI_LO])));
endmodule

// File: tb/sys_ctrl_regs_tb.sv
module sys_ctrl_regs_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        rfe_en;
  logic        sys_req;
  logic [31:0] exc_pc;
  logic        in_delay;
  logic        exc_taken;
  logic [4:0]  exc_code;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  sys_ctrl_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rfe_en    (rfe_en),
    .sys_req   (sys_req),
    .exc_pc    (exc_pc),
    .in_delay  (in_delay),
    .exc_taken (exc_taken),
    .exc_code  (exc_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
    rd_addr = 5'(idx);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(idx); wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rfe_en = 1'b1;
    @(negedge clk);
    rfe_en = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) rd_chk("R1 word after reset", i, 32'h0);
    chk("R1 exc_taken after reset", {31'd0, exc_taken}, 32'd0);
  endtask

  task automatic t_general();
    wr(3, 32'hA5A5_5A5A);
    wr(31, 32'h1234_5678);
    wr(14, 32'hCAFE_F00D);
    rd_chk("R3 word 3", 3, 32'hA5A5_5A5A);
    rd_chk("R2 same-cycle read word 31", 31, 32'h1234_5678);
    rd_chk("R3 word 14 by write", 14, 32'hCAFE_F00D);
  endtask

  task automatic t_status_cause();
    exc_pc = 32'h0000_0400; in_delay = 1'b1;
    wr(12, 32'hFFFF_FFFE);
    #1 chk("R9 no fire, enable clear", {31'd0, exc_taken}, 32'd0);
    rd_chk("R4 status full store", 12, 32'hFFFF_FFFE);
    wr(13, 32'hFFFF_FFFF);
    #1 chk("R9 no fire after cause write", {31'd0, exc_taken}, 32'd0);
    rd_chk("R5 cause hole cleared", 13, 32'hFFFF_03FF);
    wr(12, 32'hFFFF_FFFF);
    #1 chk("R9 fire after status write", {31'd0, exc_taken}, 32'd1);
    chk("R9 interrupt code", {27'd0, exc_code}, 32'd0);
    @(negedge clk);
    #1 chk("R9 single cycle request", {31'd0, exc_taken}, 32'd0);
    rd_chk("R8 status push", 12, 32'hFFFF_FFFC);
    rd_chk("R9 cause on interrupt entry", 13, 32'hFFFF_0383);
    rd_chk("R9 return address", 14, 32'h0000_0400);
    in_delay = 1'b0;
  endtask

  task automatic t_rfe();
    wr(12, 32'h0000_0014);
    pop();
    rd_chk("R6 stack pop", 12, 32'h0000_0015);
  endtask

  task automatic t_syscall();
    wr(13, 32'h0000_0401);
    #1 chk("R9 no fire with empty mask", {31'd0, exc_taken}, 32'd0);
    rd_chk("R5 cause bit 10 dropped", 13, 32'h0000_0001);
    @(negedge clk);
    sys_req = 1'b1; exc_pc = 32'h8000_1234; in_delay = 1'b0;
    #1 chk("R7 syscall request now", {31'd0, exc_taken}, 32'd1);
    chk("R7 syscall code", {27'd0, exc_code}, 32'd8);
    @(negedge clk);
    sys_req = 1'b0;
    rd_chk("R8 status after syscall", 12, 32'h0000_0014);
    rd_chk("R7 cause after syscall", 13, 32'h0000_0021);
    rd_chk("R7 saved pc", 14, 32'h8000_1234);
    @(negedge clk);
    sys_req = 1'b1; exc_pc = 32'h8000_2000; in_delay = 1'b1;
    @(negedge clk);
    sys_req = 1'b0; in_delay = 1'b0;
    rd_chk("R8 second push", 12, 32'h0000_0010);
    rd_chk("R7 delay-slot flag", 13, 32'h8000_0021);
    rd_chk("R7 saved pc in slot", 14, 32'h8000_2000);
  endtask

  task automatic t_priority();
    @(negedge clk);
    sys_req = 1'b1; rfe_en = 1'b1; exc_pc = 32'h0000_0100;
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h0000_DEAD;
    @(negedge clk);
    sys_req = 1'b0; rfe_en = 1'b0; wr_en = 1'b0;
    rd_chk("R10 write dropped under syscall", 5, 32'h0);
    rd_chk("R10 status follows entry", 12, 32'h0);
    rd_chk("R10 cause follows entry", 13, 32'h0000_0021);
    @(negedge clk);
    rfe_en = 1'b1; wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'h0000_003C;
    @(negedge clk);
    rfe_en = 1'b0; wr_en = 1'b0;
    rd_chk("R10 write dropped under pop", 12, 32'h0);
    wr(13, 32'h0000_0100);
    exc_pc = 32'h0000_0200;
    wr(12, 32'h0000_0105);
    rfe_en = 1'b1; wr_en = 1'b1; wr_addr = 5'd6; wr_data = 32'h0000_0077;
    #1 chk("R10 interrupt over pop", {31'd0, exc_taken}, 32'd1);
    @(negedge clk);
    rfe_en = 1'b0; wr_en = 1'b0;
    rd_chk("R10 status by entry not pop", 12, 32'h0000_0114);
    rd_chk("R9 cause keeps pending bit", 13, 32'h0000_0100);
    rd_chk("R10 write dropped under interrupt", 6, 32'h0);
    rd_chk("R9 saved pc", 14, 32'h0000_0200);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rfe_en = 1'b0; sys_req = 1'b0; exc_pc = '0; in_delay = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_general();
    t_status_cause();
    t_rfe();
    t_syscall();
    t_priority();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule